// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block sits between a processor load/store port and a slower word-wide memory. It holds 16 KB of data as 128 sets of two ways, each line being 64 bytes (sixteen 32-bit words). A request looks up both ways of its set in parallel. A read hit is answered in the cycle after the request is taken. A write hit is merged into the cached line with byte strobes and marks the line dirty, and memory is not written. A read miss picks a victim with a single per-set recency bit, writes the victim back first if it is dirty, then fetches the whole line and answers from it. A write miss does not allocate. The write goes into a four-entry posted queue that drains to memory in the background.

A flush pulse makes the controller walk every line and write each dirty one back to memory. The lines stay valid and become clean. All data movement uses valid/ready. Processor requests are taken only on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. The read response is a one-cycle pulse that the processor must accept. On the memory side a request, address or write beat that is offered and not yet taken must stay unchanged until it is taken. The cache is always ready for refill beats while a fill is in progress.

Top module: `dcwb_cache`

## Requirements
- R1: After reset `cpu_req_ready` is 1, `cpu_rsp_valid` and `flush_busy` are 0, and every line is invalid, so the first read of any address is a miss.
- R2: Address bits [31:13] form the tag, bits [12:6] select the set and bits [5:2] select the word. A read that hits raises `cpu_rsp_valid` with the word in the cycle after it is accepted and causes no memory traffic.
- R3: A read miss issues exactly one line request whose address is the request address with bits [5:0] cleared. It takes 16 beats in ascending word order, stores the line as valid and clean, and returns the requested word.
- R4: On a miss the line goes into way 0 when the set's recency bit is 0 and into way 1 when it is 1. Every hit, including the hit that completes a read miss, sets the bit to the way not just touched. A write miss leaves the bit unchanged.
- R5: A write hit merges the bytes whose `cpu_req_wstrb` bit is 1 into the cached word, marks the line dirty and produces no memory write.
- R6: A write miss emits one memory write beat with the request's address, data and strobes and with `mem_wr_last`=1. It leaves tags and data unchanged, so a later read of that address misses.
- R7: Posted writes wait in a 4-entry FIFO. A write miss that finds the FIFO full stalls the processor with `cpu_req_ready` low. A read miss issues no line request until the FIFO is empty, so the read sees the posted data.
- R8: A read miss whose victim is valid and dirty first writes the victim line back as 16 beats of the old line's word addresses with strobes 4'hF. `mem_wr_last` is set on the 16th beat. All 16 beats complete before the line request for the new line is issued.
- R9: A one-cycle `flush_start` while idle raises `flush_busy`. It waits for the posted FIFO to empty, then writes back every dirty line as in R8 and leaves each line valid and clean. It accepts no processor request until `flush_busy` falls. A flush with no dirty lines writes nothing.
- R10: A memory line request or write beat that is offered and not yet taken stays asserted with unchanged address and data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request offered |
| cpu_req_ready | output | 1 | Cache takes the request this cycle |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_wstrb | input | 4 | Store byte enables |
| cpu_rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rsp_rdata | output | 32 | Load data |
| flush_start | input | 1 | Pulse to write back all dirty lines |
| flush_busy | output | 1 | Flush in progress |
| mem_rd_req_valid | output | 1 | Line fetch request offered |
| mem_rd_req_ready | input | 1 | Memory takes the line request |
| mem_rd_req_addr | output | 32 | Line-aligned fetch address |
| mem_rd_valid | input | 1 | Refill beat valid |
| mem_rd_ready | output | 1 | Cache accepts refill beats |
| mem_rd_data | input | 32 | Refill beat data |
| mem_wr_valid | output | 1 | Write beat offered |
| mem_wr_ready | input | 1 | Memory takes the write beat |
| mem_wr_addr | output | 32 | Write beat byte address |
| mem_wr_data | output | 32 | Write beat data |
| mem_wr_strb | output | 4 | Write beat byte enables |
| mem_wr_last | output | 1 | Final beat of a burst or single posted write |

## Verification
Loads run first to a cold line, then to other words of the same line. The count of line requests separates a miss from a hit. Three tags that share one set are touched in a chosen order, so a wrong victim choice shows up as extra misses or as an unexpected write-back of the dirty way. Stores with partial strobes go to cached lines and to uncached lines, which separates merging into a dirty line from posting to the queue. Memory write acceptance is held low to fill the queue and to hold a load miss behind it, and a flush is run twice to separate real write-backs from redundant ones.

// File: rtl/dcwb_pkg.sv
`timescale 1ns/1ps
package dcwb_pkg;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_DRAIN, S_EVICT, S_FREQ, S_FILL, S_FL_DRAIN, S_FL_SCAN
  } dc_state_t;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [BW-1:0] strb;
  } post_wr_t;
endpackage

// File: rtl/dcwb_tags.sv
`timescale 1ns/1ps
module dcwb_tags #(
  parameter int SETS  = 128,
  parameter int TAG_W = 19,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SET_W-1:0]      rd_set,
  output logic [1:0]            vld,
  output logic [1:0]            dty,
  output logic [1:0][TAG_W-1:0] tag,
  output logic                  lru,
  input  logic                  fill_en,
  input  logic                  fill_way,
  input  logic [SET_W-1:0]      fill_set,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic                  dset_en,
  input  logic                  dset_way,
  input  logic [SET_W-1:0]      dset_set,
  input  logic                  dclr_en,
  input  logic                  dclr_way,
  input  logic [SET_W-1:0]      dclr_set,
  input  logic                  lru_en,
  input  logic [SET_W-1:0]      lru_set,
  input  logic                  lru_val
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  v_q, d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        d_q <= '0;
      end else begin
        if (fill_en && fill_way == 1'(w)) begin
          v_q[fill_set] <= 1'b1;
          d_q[fill_set] <= 1'b0;
        end
        if (dset_en && dset_way == 1'(w)) d_q[dset_set] <= 1'b1;
        if (dclr_en && dclr_way == 1'(w)) d_q[dclr_set] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == 1'(w)) tag_q[fill_set] <= fill_tag;
    end

    assign vld[w] = v_q[rd_set];
    assign dty[w] = d_q[rd_set];
    assign tag[w] = tag_q[rd_set];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q <= '0;
    else if (lru_en) lru_q[lru_set] <= lru_val;
  end

  assign lru = lru_q[rd_set];
endmodule

// File: rtl/dcwb_data.sv
`timescale 1ns/1ps
module dcwb_data
  import dcwb_pkg::*;
#(
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 16,
  localparam int IDX_W = $clog2(SETS * LINE_WORDS)
) (
  input  logic               clk,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [1:0][DW-1:0] rd_data,
  input  logic               we,
  input  logic               wr_way,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [BW-1:0]      wr_strb,
  input  logic [DW-1:0]      wr_data
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DW-1:0] mem_q [SETS*LINE_WORDS];

    always_ff @(posedge clk) begin
      if (we && wr_way == 1'(w)) begin
        for (int b = 0; b < BW; b++) begin
          if (wr_strb[b]) mem_q[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
    end

    assign rd_data[w] = mem_q[rd_idx];
  end
endmodule

// File: rtl/dcwb_wbuf.sv
`timescale 1ns/1ps
module dcwb_wbuf
  import dcwb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  post_wr_t push_item,
  input  logic     pop,
  output post_wr_t head,
  output logic     empty,
  output logic     full
);
  post_wr_t         slot_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [PTR_W:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wp_q] <= push_item;
  end

  assign head  = slot_q[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (PTR_W+1)'(DEPTH));
endmodule

// File: rtl/dcwb_cache.sv
`timescale 1ns/1ps
module dcwb_cache
  import dcwb_pkg::*;
#(
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 16,
  parameter int WB_DEPTH   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic          cpu_req_we,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  input  logic [BW-1:0] cpu_req_wstrb,
  output logic          cpu_rsp_valid,
  output logic [DW-1:0] cpu_rsp_rdata,
  input  logic          flush_start,
  output logic          flush_busy,
  output logic          mem_rd_req_valid,
  input  logic          mem_rd_req_ready,
  output logic [AW-1:0] mem_rd_req_addr,
  input  logic          mem_rd_valid,
  output logic          mem_rd_ready,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic [BW-1:0] mem_wr_strb,
  output logic          mem_wr_last
);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int OFF_W  = WORD_W + $clog2(BW);
  localparam int TAG_W  = AW - SET_W - OFF_W;
  localparam int IDX_W  = SET_W + WORD_W;
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);

  dc_state_t         st;
  logic              rq_we;
  logic [AW-1:0]     rq_addr;
  logic [DW-1:0]     rq_wdata;
  logic [BW-1:0]     rq_wstrb;
  logic [WORD_W-1:0] beat;
  logic              flushing;
  logic              v_way, v_need;
  logic [SET_W-1:0]  v_set;
  logic [TAG_W-1:0]  v_tag;
  logic [SET_W:0]    scan;

  logic [SET_W-1:0]  rq_set;
  logic [TAG_W-1:0]  rq_tag;
  logic [WORD_W-1:0] rq_word;
  assign rq_set  = rq_addr[OFF_W +: SET_W];
  assign rq_tag  = rq_addr[AW-1 -: TAG_W];
  assign rq_word = rq_addr[$clog2(BW) +: WORD_W];

  // tag store
  logic [SET_W-1:0]       tr_set;
  logic [1:0]             vld, dty;
  logic [1:0][TAG_W-1:0]  tag;
  logic                   lru;
  logic                   hit0, hit1, hit, hway;
  logic                   scan_way;
  logic [SET_W-1:0]       scan_set;

  assign scan_way = scan[0];
  assign scan_set = scan[SET_W:1];
  assign tr_set   = (st == S_FL_SCAN) ? scan_set : rq_set;

  assign hit0 = vld[0] && (tag[0] == rq_tag);
  assign hit1 = vld[1] && (tag[1] == rq_tag);
  assign hit  = hit0 || hit1;
  assign hway = hit1;

  logic look_rd_hit, look_wr_hit, fill_beat, fill_done, evict_beat, evict_done;
  assign look_rd_hit = (st == S_LOOK) && !rq_we && hit;
  assign look_wr_hit = (st == S_LOOK) && rq_we && hit;
  assign fill_beat   = (st == S_FILL) && mem_rd_valid;
  assign fill_done   = fill_beat && (beat == LAST_BEAT);
  assign evict_beat  = (st == S_EVICT) && mem_wr_ready;
  assign evict_done  = evict_beat && (beat == LAST_BEAT);

  dcwb_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (tr_set),
    .vld      (vld),
    .dty      (dty),
    .tag      (tag),
    .lru      (lru),
    .fill_en  (fill_done),
    .fill_way (v_way),
    .fill_set (rq_set),
    .fill_tag (rq_tag),
    .dset_en  (look_wr_hit),
    .dset_way (hway),
    .dset_set (rq_set),
    .dclr_en  (evict_done),
    .dclr_way (v_way),
    .dclr_set (v_set),
    .lru_en   ((st == S_LOOK) && hit),
    .lru_set  (rq_set),
    .lru_val  (!hway)
  );

  // data store
  logic [IDX_W-1:0]   d_rd_idx, d_wr_idx;
  logic [1:0][DW-1:0] d_rd;
  logic               d_we, d_way;
  logic [BW-1:0]      d_strb;
  logic [DW-1:0]      d_wdata;

  assign d_rd_idx = (st == S_EVICT) ? {v_set, beat} : {rq_set, rq_word};
  assign d_we     = look_wr_hit || fill_beat;
  assign d_way    = (st == S_FILL) ? v_way : hway;
  assign d_wr_idx = (st == S_FILL) ? {rq_set, beat} : {rq_set, rq_word};
  assign d_strb   = (st == S_FILL) ? '1 : rq_wstrb;
  assign d_wdata  = (st == S_FILL) ? mem_rd_data : rq_wdata;

  dcwb_data #(.SETS(SETS), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk     (clk),
    .rd_idx  (d_rd_idx),
    .rd_data (d_rd),
    .we      (d_we),
    .wr_way  (d_way),
    .wr_idx  (d_wr_idx),
    .wr_strb (d_strb),
    .wr_data (d_wdata)
  );

  // posted write queue
  post_wr_t wb_in, wb_head;
  logic     wb_push, wb_pop, wb_empty, wb_full;

  assign wb_in   = '{addr: rq_addr, data: rq_wdata, strb: rq_wstrb};
  assign wb_push = (st == S_LOOK) && rq_we && !hit && !wb_full;
  assign wb_pop  = (st != S_EVICT) && !wb_empty && mem_wr_ready;

  dcwb_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wb_push),
    .push_item (wb_in),
    .pop       (wb_pop),
    .head      (wb_head),
    .empty     (wb_empty),
    .full      (wb_full)
  );

  // memory write port: line write-back has the port to itself
  always_comb begin
    if (st == S_EVICT) begin
      mem_wr_valid = 1'b1;
      mem_wr_addr  = {v_tag, v_set, beat, {($clog2(BW)){1'b0}}};
      mem_wr_data  = d_rd[v_way];
      mem_wr_strb  = '1;
      mem_wr_last  = (beat == LAST_BEAT);
    end else begin
      mem_wr_valid = !wb_empty;
      mem_wr_addr  = wb_head.addr;
      mem_wr_data  = wb_head.data;
      mem_wr_strb  = wb_head.strb;
      mem_wr_last  = 1'b1;
    end
  end

  assign mem_rd_req_valid = (st == S_FREQ);
  assign mem_rd_req_addr  = {rq_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_rd_ready     = (st == S_FILL);

  assign cpu_req_ready = (st == S_IDLE) && !flush_start;
  assign cpu_rsp_valid = look_rd_hit;
  assign cpu_rsp_rdata = d_rd[hway];
  assign flush_busy    = (st == S_FL_DRAIN) || (st == S_FL_SCAN) ||
                         ((st == S_EVICT) && flushing);

  // controller
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rq_we    <= 1'b0;
      rq_addr  <= '0;
      rq_wdata <= '0;
      rq_wstrb <= '0;
      beat     <= '0;
      flushing <= 1'b0;
      v_way    <= 1'b0;
      v_need   <= 1'b0;
      v_set    <= '0;
      v_tag    <= '0;
      scan     <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (flush_start) begin
            flushing <= 1'b1;
            scan     <= '0;
            st       <= S_FL_DRAIN;
          end else if (cpu_req_valid) begin
            rq_we    <= cpu_req_we;
            rq_addr  <= cpu_req_addr;
            rq_wdata <= cpu_req_wdata;
            rq_wstrb <= cpu_req_wstrb;
            st       <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (hit) begin
            st <= S_IDLE;
          end else if (rq_we) begin
            if (!wb_full) st <= S_IDLE;
          end else begin
            v_way  <= lru;
            v_set  <= rq_set;
            v_tag  <= tag[lru];
            v_need <= vld[lru] && dty[lru];
            st     <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          if (wb_empty) begin
            beat <= '0;
            st   <= v_need ? S_EVICT : S_FREQ;
          end
        end
        S_EVICT: begin
          if (mem_wr_ready) begin
            beat <= beat + 1'b1;
            if (beat == LAST_BEAT) st <= flushing ? S_FL_SCAN : S_FREQ;
          end
        end
        S_FREQ: begin
          if (mem_rd_req_ready) begin
            beat <= '0;
            st   <= S_FILL;
          end
        end
        S_FILL: begin
          if (mem_rd_valid) begin
            beat <= beat + 1'b1;
            if (beat == LAST_BEAT) st <= S_LOOK;
          end
        end
        S_FL_DRAIN: begin
          if (wb_empty) st <= S_FL_SCAN;
        end
        S_FL_SCAN: begin
          if (vld[scan_way] && dty[scan_way]) begin
            v_way <= scan_way;
            v_set <= scan_set;
            v_tag <= tag[scan_way];
            beat  <= '0;
            st    <= S_EVICT;
          end else if (&scan) begin
            flushing <= 1'b0;
            st       <= S_IDLE;
          end else begin
            scan <= scan + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcwb_cache_chk.sv
`timescale 1ns/1ps
module dcwb_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req_ready,
  input logic        cpu_rsp_valid,
  input logic        flush_busy,
  input logic        mem_rd_req_valid,
  input logic        mem_rd_req_ready,
  input logic [31:0] mem_rd_req_addr,
  input logic        mem_wr_valid,
  input logic        mem_wr_ready,
  input logic [31:0] mem_wr_addr,
  input logic [31:0] mem_wr_data,
  input logic        wb_empty
);
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid && !mem_rd_req_ready |=> mem_rd_req_valid && $stable(mem_rd_req_addr));

  a_r7_fetch_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid |-> wb_empty);

  a_r9_no_accept_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !cpu_req_ready);

  a_r2_rsp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !cpu_req_ready && !flush_busy);
endmodule

bind dcwb_cache dcwb_cache_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cpu_req_ready    (cpu_req_ready),
  .cpu_rsp_valid    (cpu_rsp_valid),
  .flush_busy       (flush_busy),
  .mem_rd_req_valid (mem_rd_req_valid),
  .mem_rd_req_ready (mem_rd_req_ready),
  .mem_rd_req_addr  (mem_rd_req_addr),
  .mem_wr_valid     (mem_wr_valid),
  .mem_wr_ready     (mem_wr_ready),
  .mem_wr_addr      (mem_wr_addr),
  .mem_wr_data      (mem_wr_data),
  .wb_empty         (wb_empty)
);

// File: tb/dcwb_cache_test.sv
`timescale 1ns/1ps
module dcwb_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic        cpu_req_ready, cpu_rsp_valid, flush_busy;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0, cpu_rsp_rdata;
  logic [3:0]  cpu_req_wstrb = '0;
  logic        flush_start = 1'b0;
  logic        mem_rd_req_valid, mem_rd_req_ready, mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_req_addr, mem_rd_data;
  logic        mem_wr_valid, mem_wr_ready, mem_wr_last;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic [3:0]  mem_wr_strb;

  always #5 clk = ~clk;

  dcwb_cache uut (.*);

  int checks = 0, failures = 0;
  int rd_reqs = 0, wr_beats = 0, wr_lasts = 0, wr_at_rd = 0;
  logic [31:0] last_rd_addr = '0, rbase, wa;
  logic [31:0] exp_q [$];
  logic [31:0] mm [logic [31:0]];
  logic [31:0] rf [logic [31:0]];
  bit wr_hold = 1'b0;
  assign mem_wr_ready = !wr_hold;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h0009_E377) ^ 32'hC3A5_1E0F;
  endfunction
  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction
  function automatic logic [31:0] mm_get(input logic [31:0] a);
    return mm.exists(a) ? mm[a] : pat(a);
  endfunction
  function automatic logic [31:0] rf_get(input logic [31:0] a);
    return rf.exists(a) ? rf[a] : pat(a);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: write side
  always @(posedge clk) begin
    if (rst_n && mem_wr_valid && mem_wr_ready) begin
      wa = {mem_wr_addr[31:2], 2'b00};
      mm[wa] = merge(mm_get(wa), mem_wr_data, mem_wr_strb);
      wr_beats++;
      if (mem_wr_last) wr_lasts++;
    end
  end

  // memory model: line fetch side
  initial begin
    mem_rd_req_ready = 1'b0;
    mem_rd_valid = 1'b0;
    mem_rd_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_req_valid) begin
        rbase = mem_rd_req_addr;
        mem_rd_req_ready = 1'b1;
        @(negedge clk);
        mem_rd_req_ready = 1'b0;
        rd_reqs++;
        wr_at_rd = wr_beats;
        last_rd_addr = rbase;
        for (int b = 0; b < 16; b++) begin
          mem_rd_valid = 1'b1;
          mem_rd_data = mm_get(rbase + 32'(b * 4));
          while (!mem_rd_ready) @(negedge clk);
          @(negedge clk);
        end
        mem_rd_valid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cpu_rsp_valid) begin
      if (exp_q.size() == 0) chk("R3 unexpected response", cpu_rsp_rdata, 32'hx);
      else chk("R3 read data", cpu_rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic cpu_read(input logic [31:0] a, input bit hit_exp);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = a;
    cpu_req_wdata = '0; cpu_req_wstrb = '0;
    exp_q.push_back(rf_get(a));
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (hit_exp) chk("R2 hit answers next cycle", {31'b0, cpu_rsp_valid}, 32'd1);
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = a;
    cpu_req_wdata = d; cpu_req_wstrb = s;
    rf[a] = merge(rf_get(a), d, s);
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (!(cpu_req_ready && exp_q.size() == 0)) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_start = 1'b1;
    @(negedge clk);
    flush_start = 1'b0;
    chk("R9 busy during flush", {31'b0, flush_busy}, 32'd1);
    while (flush_busy) @(negedge clk);
    settle();
  endtask

  localparam logic [31:0] A  = 32'h0001_0040;
  localparam logic [31:0] B  = A + 32'h2000;
  localparam logic [31:0] C  = A + 32'h4000;
  localparam logic [31:0] D  = 32'h0003_0100;
  localparam logic [31:0] E  = 32'h0005_0200;
  localparam logic [31:0] F0 = 32'h0007_0300;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  int r0, w0, l0;
  logic [31:0] hold_addr;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", {31'b0, cpu_req_ready}, 32'd1);
    chk("R1 no response after reset", {31'b0, cpu_rsp_valid}, 32'd0);
    chk("R1 not flushing after reset", {31'b0, flush_busy}, 32'd0);

    // R1/R3 cold miss
    r0 = rd_reqs;
    cpu_read(A + 8, 1'b0); settle();
    chk("R1 first read misses", 32'(rd_reqs - r0), 32'd1);
    chk("R3 line aligned fetch", last_rd_addr, A & ~32'h3F);

    // R2 hits to other words
    r0 = rd_reqs;
    cpu_read(A + 12, 1'b1); cpu_read(A + 60, 1'b1); settle();
    chk("R2 hits fetch nothing", 32'(rd_reqs - r0), 32'd0);

    // R5 write hit with partial strobes
    w0 = wr_beats;
    cpu_write(A + 12, 32'hAABB_CCDD, 4'b0101); settle();
    chk("R5 write hit no memory write", 32'(wr_beats - w0), 32'd0);
    cpu_read(A + 12, 1'b1); settle();

    // R4 victim choice: A in way0 dirty, B into way1
    r0 = rd_reqs;
    cpu_read(B, 1'b0); cpu_read(A, 1'b1); settle();
    w0 = wr_beats;
    cpu_read(C, 1'b0); settle();
    chk("R4 clean way1 victim, no write-back", 32'(wr_beats - w0), 32'd0);
    r0 = rd_reqs;
    cpu_read(A + 4, 1'b1); settle();
    chk("R4 way0 line kept", 32'(rd_reqs - r0), 32'd0);
    cpu_read(B + 4, 1'b0); settle();
    chk("R4 evicted line misses", 32'(rd_reqs - r0), 32'd1);

    // R8 dirty victim (A in way0) written back before fetch of C
    w0 = wr_beats; l0 = wr_lasts;
    cpu_read(C + 8, 1'b0); settle();
    chk("R8 sixteen write-back beats", 32'(wr_beats - w0), 32'd16);
    chk("R8 write-back before fetch", 32'(wr_at_rd - w0), 32'd16);
    chk("R8 one last flag", 32'(wr_lasts - l0), 32'd1);
    chk("R8 merged word in memory", mm_get(A + 12), rf_get(A + 12));

    // R6 write miss is posted, no allocation
    w0 = wr_beats; l0 = wr_lasts;
    cpu_write(D, 32'h1122_3344, 4'hF); settle();
    chk("R6 single posted beat", 32'(wr_beats - w0), 32'd1);
    chk("R6 posted beat is last", 32'(wr_lasts - l0), 32'd1);
    chk("R6 memory updated", mm_get(D), 32'h1122_3344);
    r0 = rd_reqs;
    cpu_read(D, 1'b0); settle();
    chk("R6 no allocation on write miss", 32'(rd_reqs - r0), 32'd1);

    // R7 queue full stalls; R10 held beat stable
    wr_hold = 1'b1;
    w0 = wr_beats;
    for (int i = 0; i < 5; i++) cpu_write(E + 32'(4 * i), 32'hE000_0000 + 32'(i), 4'hF);
    hold_addr = mem_wr_addr;
    repeat (10) @(negedge clk);
    chk("R7 stall when queue full", {31'b0, cpu_req_ready}, 32'd0);
    chk("R10 held beat stays valid", {31'b0, mem_wr_valid}, 32'd1);
    chk("R10 held address stable", mem_wr_addr, hold_addr);
    wr_hold = 1'b0;
    settle();
    chk("R7 all posted writes drained", 32'(wr_beats - w0), 32'd5);
    chk("R7 queue order last entry", mm_get(E + 16), 32'hE000_0004);

    // R7 read miss waits for drain
    wr_hold = 1'b1;
    cpu_write(F0, 32'h0F0F_5A5A, 4'hF);
    cpu_write(F0 + 4, 32'h1234_0000, 4'b1100);
    r0 = rd_reqs;
    fork cpu_read(F0, 1'b0); join_none
    repeat (15) @(negedge clk);
    chk("R7 no fetch while queue holds data", 32'(rd_reqs - r0), 32'd0);
    wr_hold = 1'b0;
    settle();

    // R9 flush writes back dirty lines, keeps them valid
    cpu_write(B, 32'hBEEF_0001, 4'hF);
    cpu_write(D, 32'hDEAD_0002, 4'hF);
    settle();
    w0 = wr_beats; l0 = wr_lasts;
    do_flush();
    chk("R9 two dirty lines written", 32'(wr_beats - w0), 32'd32);
    chk("R9 two bursts", 32'(wr_lasts - l0), 32'd2);
    chk("R9 memory holds B", mm_get(B), 32'hBEEF_0001);
    chk("R9 memory holds D", mm_get(D), 32'hDEAD_0002);
    r0 = rd_reqs;
    cpu_read(B, 1'b1); settle();
    chk("R9 line stays valid", 32'(rd_reqs - r0), 32'd0);
    w0 = wr_beats;
    do_flush();
    chk("R9 clean flush writes nothing", 32'(wr_beats - w0), 32'd0);

    chk("R3 all responses seen", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule